// File: doc/BRIEF.md
# DMA Request Routing Multiplexer

This block sits between a chip's peripherals and its DMA engine. Each DMA channel gets its own byte-wide configuration register, written and read over a small register bus. The register names one of 64 request sources for the channel. Whatever request the chosen source raises is passed to that channel's request line toward the engine.

Source code 0 turns the channel off. Codes 60 to 63 are always-asserted slots, which let a channel run unpaced or under software control. Codes 1 to 59 map to peripheral request inputs. Some of those codes are reserved and never assert a request.

The lowest-numbered channels can also be paced by an external periodic timer. When a channel is in trigger mode, each timer pulse lets exactly one request through. On the higher channels the trigger bit is stored but ignored.

Top module: `dmx_req_router`

## Requirements
- R1: After reset every configuration byte reads as 0x00 and every channel request output is low, whatever the peripheral inputs are.
- R2: A bus write to channel address A stores the data byte, and from the next clock edge on a read at address A returns that byte. A read is combinational from the address. The byte layout is: bit 7 enable, bit 6 trigger mode, bits 5:0 source code.
- R3: While a channel's enable bit (bit 7) is 0, its request output is low for every source code and input pattern.
- R4: An enabled channel with source code 0 never raises a request.
- R5: An enabled channel that is not in trigger mode and has a source code of 60, 61, 62 or 63 holds its request high, independent of the peripheral inputs.
- R6: An enabled channel that is not in trigger mode and has a non-reserved source code k in the range 1 to 59 drives its request equal to peripheral input k, in the same cycle and without a register stage.
- R7: Reserved source codes act as a request that is never asserted. With the default parameters the reserved codes are 1, 58 and 59.
- R8: On a trigger-capable channel (channels 0 to TRIG_CH-1, default 0 to 3) with bit 6 set, no request passes until a trigger pulse is seen. A pulse sampled at one clock edge lets exactly one cycle of asserted source request through, starting in the cycle after the pulse or at the first later cycle in which the source is high. After that, requests are blocked until the next pulse.
- R9: On channels TRIG_CH and above, bit 6 has no effect: the request follows the selected source exactly as in R5 to R7.
- R10: Leaving trigger mode, by clearing either bit 6 or bit 7, discards an armed pulse. A trigger pulse that arrives while the channel is not in trigger mode is also discarded. On re-entering trigger mode, no request passes until a new pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | $clog2(NUM_CH) | Channel register address for reads and writes |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 8 | Stored byte of the addressed channel |
| periph_req_i | input | 59 ([59:1]) | Peripheral requests; bit k belongs to source code k |
| trig_pulse_i | input | TRIG_CH | Periodic timer pulses, one per trigger-capable channel |
| dma_req_o | output | NUM_CH | Request line per channel toward the DMA engine |

## Verification
Most faults in this block appear at the request outputs with no delay. A wrong selector decode, a wrong reserved mask or a broken always-on slot changes `dma_req_o` combinationally. The bench therefore compares every channel against every source code under several input patterns. The one hidden state bit per channel is the trigger arm flag. If it is stuck or not cleared, the fault shows one cycle after a pulse or after a mode change, as a missing request, a doubled request, or a request with no pulse before it. The trigger sequences sample exactly in those cycles.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int CFG_W     = 8;
  localparam int SEL_W     = 6;
  localparam int AON_FIRST = 60;
  localparam int PERIPH_HI = AON_FIRST - 1;

  typedef struct packed {
    logic             en;
    logic             trig;
    logic [SEL_W-1:0] src;
  } dmx_cfg_t;
endpackage

// File: rtl/dmx_cfg_regs.sv
module dmx_cfg_regs
  import dmx_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output logic [CFG_W-1:0]     rdata_o,
  output dmx_cfg_t [NUM_CH-1:0] cfg_o
);
  logic              addr_ok;
  logic [NUM_CH-1:0] we;

  generate
    if (NUM_CH == (1 << AW)) begin : g_full
      assign addr_ok = 1'b1;
    end else begin : g_part
      assign addr_ok = (addr_i < AW'(NUM_CH));
    end
  endgenerate

  always_comb begin
    we = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      we[c] = wr_i && addr_ok && (addr_i == AW'(c));
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_ok && (addr_i == AW'(c))) rdata_o = cfg_o[c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[c] <= '0;
      end else if (we[c]) begin
        cfg_o[c] <= dmx_cfg_t'(wdata_i);
      end
    end
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_ok) |=> (cfg_o[$past(addr_i)] == dmx_cfg_t'($past(wdata_i))));
endmodule

// File: rtl/dmx_src_pick.sv
module dmx_src_pick
  import dmx_pkg::*;
#(
  parameter logic [63:0] RSVD_MASK = 64'h0C00_0000_0000_0002
) (
  input  logic [PERIPH_HI:1] periph_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    if (sel_i >= SEL_W'(AON_FIRST)) begin
      hit_o = 1'b1;
    end else begin
      for (int k = 1; k <= PERIPH_HI; k++) begin
        if ((sel_i == SEL_W'(k)) && !RSVD_MASK[k]) hit_o = periph_i[k];
      end
    end
  end
endmodule

// File: rtl/dmx_trig_gate.sv
module dmx_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic routed_i,
  input  logic pulse_i,
  output logic pass_o
);
  logic armed_q;
  logic armed_d;

  assign pass_o = mode_i ? (armed_q && routed_i) : routed_i;

  always_comb begin
    armed_d = armed_q;
    if (!mode_i)      armed_d = 1'b0;
    else if (pulse_i) armed_d = 1'b1;
    else if (pass_o)  armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R8
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(pulse_i));
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && pass_o && !pulse_i) |=> !armed_q);
  // R10
  mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> !armed_q);
endmodule

// File: rtl/dmx_req_router.sv
module dmx_req_router
  import dmx_pkg::*;
#(
  parameter int          NUM_CH    = 8,
  parameter int          TRIG_CH   = 4,
  parameter logic [63:0] RSVD_MASK = 64'h0C00_0000_0000_0002,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [CFG_W-1:0]     bus_wdata_i,
  output logic [CFG_W-1:0]     bus_rdata_o,
  input  logic [PERIPH_HI:1]   periph_req_i,
  input  logic [TRIG_CH-1:0]   trig_pulse_i,
  output logic [NUM_CH-1:0]    dma_req_o
);
  dmx_cfg_t [NUM_CH-1:0] cfg;
  logic     [NUM_CH-1:0] routed;
  logic     [NUM_CH-1:0] passed;

  dmx_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmx_src_pick #(.RSVD_MASK(RSVD_MASK)) u_pick (
      .periph_i (periph_req_i),
      .sel_i    (cfg[c].src),
      .hit_o    (routed[c])
    );

    if (c < TRIG_CH) begin : g_trig
      dmx_trig_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (cfg[c].en && cfg[c].trig),
        .routed_i (routed[c]),
        .pulse_i  (trig_pulse_i[c]),
        .pass_o   (passed[c])
      );
      // R5
      aon_trig_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[c].en && !cfg[c].trig && (cfg[c].src >= SEL_W'(AON_FIRST))) |-> dma_req_o[c]);
    end else begin : g_plain
      assign passed[c] = routed[c];
      // R5, R9
      aon_plain_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[c].en && (cfg[c].src >= SEL_W'(AON_FIRST))) |-> dma_req_o[c]);
    end

    assign dma_req_o[c] = cfg[c].en && passed[c];

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[c].en |-> !dma_req_o[c]);
    // R4
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[c].src == '0) |-> !dma_req_o[c]);
    // R7
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      RSVD_MASK[cfg[c].src] |-> !dma_req_o[c]);
  end
endmodule

// File: tb/dmx_req_router_bench.sv
module dmx_req_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int NTR = 4;
  localparam int AW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [59:1]    periph = '0;
  logic [NTR-1:0] trig = '0;
  logic [NCH-1:0] dma_req;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmx_req_router u_dmx_req_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_i     (bus_wr),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .periph_req_i (periph),
    .trig_pulse_i (trig),
    .dma_req_o    (dma_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] b);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(ch); bus_wdata = b;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic exp_hit(input int code, input logic [59:1] pv);
    if (code == 0) return 1'b0;
    if (code >= 60) return 1'b1;
    if (code == 1 || code == 58 || code == 59) return 1'b0;
    return pv[code];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    periph = '1;
    #1;
    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      bus_addr = AW'(c); #1;
      chk("R1 cfg", 64'(bus_rdata), 64'h0);
    end
    chk("R1 req", 64'(dma_req), 64'h0);

    // R2: write and read back
    for (int c = 0; c < NCH; c++) wr(c, 8'(8'h3C ^ (c * 37)));
    for (int c = 0; c < NCH; c++) begin
      bus_addr = AW'(c); #1;
      chk("R2 readback", 64'(bus_rdata), 64'(8'(8'h3C ^ (c * 37))));
    end
    for (int c = 0; c < NCH; c++) wr(c, 8'h00);

    // R4 R5 R6 R7 R9: every channel, every code, three patterns
    for (int c = 0; c < NCH; c++) begin
      for (int code = 0; code < 64; code++) begin
        wr(c, {1'b1, (c >= NTR), code[5:0]});
        for (int p = 0; p < 3; p++) begin
          logic [59:1] pv;
          for (int k = 1; k <= 59; k++) pv[k] = (p == 0) ? 1'b1 : (p == 1) ? 1'b0 : k[0];
          periph = pv; #1;
          chk((code == 0) ? "R4" : (code >= 60) ? "R5" :
              (code == 1 || code >= 58) ? "R7" : (c >= NTR) ? "R9" : "R6",
              64'(dma_req), 64'(exp_hit(code, pv)) << c);
        end
      end
      wr(c, 8'h00);
    end

    // R3: enable clear forces low
    periph = '1;
    for (int c = 0; c < NCH; c++) begin
      wr(c, 8'h7F);
      chk("R3 disabled aon", 64'(dma_req), 64'h0);
      wr(c, 8'h45);
      chk("R3 disabled periph", 64'(dma_req), 64'h0);
      wr(c, 8'h00);
    end

    // R8: channel 2 paced by pulses, source code 5
    periph = '0; periph[5] = 1'b1;
    wr(2, 8'hC5);
    chk("R8 no pulse", 64'(dma_req), 64'h0);
    tick();
    chk("R8 no pulse later", 64'(dma_req), 64'h0);
    @(negedge clk); trig[2] = 1'b1;
    @(negedge clk); trig[2] = 1'b0; #1;
    chk("R8 one pass", 64'(dma_req), 64'h4);
    tick();
    chk("R8 blocked after pass", 64'(dma_req), 64'h0);
    tick();
    chk("R8 still blocked", 64'(dma_req), 64'h0);
    // pulse while source low, request waits for source
    periph[5] = 1'b0;
    @(negedge clk); trig[2] = 1'b1;
    @(negedge clk); trig[2] = 1'b0; #1;
    chk("R8 armed src low", 64'(dma_req), 64'h0);
    tick(); tick();
    periph[5] = 1'b1; #1;
    chk("R8 late source", 64'(dma_req), 64'h4);
    tick();
    chk("R8 late source single", 64'(dma_req), 64'h0);

    // R10: arm, leave trigger mode, re-enter
    periph[5] = 1'b0;
    @(negedge clk); trig[2] = 1'b1;
    @(negedge clk); trig[2] = 1'b0;
    wr(2, 8'h85);
    wr(2, 8'hC5);
    periph[5] = 1'b1; #1;
    chk("R10 arm dropped", 64'(dma_req), 64'h0);
    // pulse while disabled is ignored
    wr(2, 8'h45);
    @(negedge clk); trig[2] = 1'b1;
    @(negedge clk); trig[2] = 1'b0;
    wr(2, 8'hC5);
    chk("R10 pulse while off", 64'(dma_req), 64'h0);
    wr(2, 8'h00);

    // R9: pulses have no effect on a high channel with trigger bit
    wr(6, 8'hC5);
    chk("R9 follows src", 64'(dma_req), 64'h40);
    periph[5] = 1'b0; #1;
    chk("R9 follows src low", 64'(dma_req), 64'h0);
    wr(6, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule